// File: doc/BRIEF.md
# 1-Wire Slave Network Address Layer

This block is the address and command layer of a slave on a 1-Wire bus. It owns a fixed 64-bit network identity: an 8-bit family code, a 48-bit serial number and an 8-bit checksum. The checksum is derived at elaboration time from the first 56 bits. After each bus reset it collects a command byte and serves the four network-address commands: read, match, skip and search. It then either grants the device to the function-command layer through `selected` or falls silent until the next bus reset.

The block sits between a bit-slot engine and a function-command decoder. The slot engine detects reset pulses and time slots on the wire. It hands over each bit the master wrote as a one-cycle `wrStrobe` with `wrBit`. When a read slot starts it raises `rdStrobe` and drives the wire from `txBit` in that cycle. A `txBit` of 1 means release the open-drain line and 0 means pull it low. The layer never holds the line low outside a read slot. The slot engine releases the line before every slot ends.

Top module: `ow_net_addr`

## Requirements
- R1: Address bit i is served at index i. Family code bits are indices 0-7, serial bits 8-55 and checksum bits 56-63, each field LSB first. The family code defaults to 30h. Command 33h makes `txBit` present index 0, then index 1, and so on, advancing by one on each `rdStrobe`. After the 64th read slot `selected` is 1.
- R2: The checksum is a CRC over address bits 0-55, processed LSB first, with polynomial x^8+x^5+x^4+1 and initial value 0. It is stored with its bit 0 at address index 56. For family 02h and serial 00000001B81Ch its value is A2h.
- R3: After a `busReset` pulse the block takes the next 8 `wrStrobe` bits as a command byte. The first bit received is the byte's bit 0.
- R4: Command CCh sets `selected` in the cycle after the 8th command bit. `selected` then stays 1 until the next `busReset`, whatever the strobes do.
- R5: Command 55h compares the next 64 written bits with address indices 0-63 in order. `selected` becomes 1 only if all 64 match. On the first mismatch the block goes idle, and further bits never select it.
- R6: Command F0h repeats the following for each index 0-63: a read slot yields the address bit, a second read slot yields its complement, and then a written bit is compared. If the written bit differs, the block withdraws and `txBit` stays 1 until `busReset`. If all 64 bits agree, `selected` is 1.
- R7: A `busReset` pulse at any point aborts the current command and clears `selected` in the next cycle. It also restarts command-byte collection with no partial bits kept.
- R8: A command byte other than 33h, 55h, CCh or F0h is ignored until the next `busReset`. `selected` stays 0, `txBit` stays 1, and later bytes are not decoded.
- R9: `txBit` is 1 whenever the block is not in a read or search send phase. This covers the time after `rstN`, command collection, match, the selected state and the idle state. Until the first `busReset` after `rstN`, all strobes are ignored.
- R10: A strobe of the wrong direction has no effect. A `wrStrobe` during read or the search send phases does not advance the bit index. An `rdStrobe` during command collection or match changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReset | input | 1 | One-cycle pulse: bus reset detected by the slot engine |
| wrStrobe | input | 1 | One-cycle pulse: the master wrote a bit |
| wrBit | input | 1 | Value of the written bit, valid with `wrStrobe` |
| rdStrobe | input | 1 | One-cycle pulse: a read slot starts and `txBit` is consumed |
| txBit | output | 1 | Bit to present in a read slot, 1 = release the line |
| selected | output | 1 | Device selected for function commands |

## Verification
The hardest state to reach from the ports is a search withdrawal deep in the address. It needs a correct command byte and dozens of exact true/complement/choice triplets, and then a single wrong choice at a chosen index. The bench therefore drives search and match from its own copy of the expected address with a selectable fault index. A behavioural model then confirms, on every clock, that `txBit` stays released for the rest of the search. The checksum is checked against a known published address by a second instance with a different identity, fed the same strobes.

// File: rtl/ow_net_addr_pkg.sv
package ow_net_addr_pkg;

  localparam int FAMILY_W = 8;
  localparam int SERIAL_W = 48;
  localparam int CRC_W    = 8;
  localparam int BODY_W   = FAMILY_W + SERIAL_W;
  localparam int ADDR_W   = BODY_W + CRC_W;
  localparam int IDX_W    = $clog2(ADDR_W);
  localparam int CMD_W    = 8;
  localparam int CNT_W    = $clog2(CMD_W);

  localparam logic [CMD_W-1:0] CMD_READ   = 8'h33;
  localparam logic [CMD_W-1:0] CMD_MATCH  = 8'h55;
  localparam logic [CMD_W-1:0] CMD_SKIP   = 8'hCC;
  localparam logic [CMD_W-1:0] CMD_SEARCH = 8'hF0;

  // x^8 + x^5 + x^4 + 1, bit-reversed for LSB-first shifting
  localparam logic [CRC_W-1:0] CRC_POLY_REV = 8'h8C;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SRCH_TRUE,
    ST_SRCH_COMP,
    ST_SRCH_PICK,
    ST_SEL
  } state_t;

  typedef struct packed {
    logic idxClr;
    logic idxInc;
    logic cmdClr;
    logic cmdShift;
  } dp_ctl_t;

  function automatic logic [CRC_W-1:0] crcBody(input logic [BODY_W-1:0] body);
    logic [CRC_W-1:0] acc;
    logic fb;
    acc = '0;
    for (int i = 0; i < BODY_W; i++) begin
      fb  = acc[0] ^ body[i];
      acc = acc >> 1;
      if (fb) acc = acc ^ CRC_POLY_REV;
    end
    return acc;
  endfunction

endpackage

// File: rtl/ow_net_addr_dp.sv
module ow_net_addr_dp
  import ow_net_addr_pkg::*;
#(
  parameter logic [FAMILY_W-1:0] FAMILY_CODE = 8'h30,
  parameter logic [SERIAL_W-1:0] SERIAL_NUM  = 48'h0000_5A3C_9E71
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_ctl_t          ctl,
  input  logic             wrBit,
  output logic             addrBit,
  output logic             lastBit,
  output logic [CMD_W-1:0] cmdNext,
  output logic             cmdFull
);

  localparam logic [BODY_W-1:0] BODY = {SERIAL_NUM, FAMILY_CODE};
  localparam logic [CRC_W-1:0]  CRC  = crcBody(BODY);
  localparam logic [ADDR_W-1:0] ADDR = {CRC, BODY};

  logic [IDX_W-1:0] bitIdx;
  logic [CMD_W-1:0] cmdReg;
  logic [CNT_W-1:0] cmdCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitIdx <= '0;
    end else if (ctl.idxClr) begin
      bitIdx <= '0;
    end else if (ctl.idxInc) begin
      bitIdx <= bitIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.cmdClr) begin
      cmdReg <= '0;
      cmdCnt <= '0;
    end else if (ctl.cmdShift) begin
      cmdReg <= cmdNext;
      cmdCnt <= cmdCnt + 1'b1;
    end
  end

  assign addrBit = ADDR[bitIdx];
  assign lastBit = (bitIdx == IDX_W'(ADDR_W - 1));
  assign cmdNext = {wrBit, cmdReg[CMD_W-1:1]};
  assign cmdFull = (cmdCnt == CNT_W'(CMD_W - 1));

endmodule

// File: rtl/ow_net_addr_ctrl.sv
module ow_net_addr_ctrl
  import ow_net_addr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busReset,
  input  logic             wrStrobe,
  input  logic             wrBit,
  input  logic             rdStrobe,
  input  logic             addrBit,
  input  logic             lastBit,
  input  logic [CMD_W-1:0] cmdNext,
  input  logic             cmdFull,
  output dp_ctl_t          ctl,
  output logic             txBit,
  output logic             selected
);

  state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_WAIT;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    if (busReset) begin
      stateNext  = ST_CMD;
      ctl.idxClr = 1'b1;
      ctl.cmdClr = 1'b1;
    end else begin
      unique case (state)
        ST_CMD: if (wrStrobe) begin
          ctl.cmdShift = 1'b1;
          if (cmdFull) begin
            unique case (cmdNext)
              CMD_READ:   stateNext = ST_READ;
              CMD_MATCH:  stateNext = ST_MATCH;
              CMD_SKIP:   stateNext = ST_SEL;
              CMD_SEARCH: stateNext = ST_SRCH_TRUE;
              default:    stateNext = ST_WAIT;
            endcase
          end
        end
        ST_READ: if (rdStrobe) begin
          if (lastBit) stateNext = ST_SEL;
          else         ctl.idxInc = 1'b1;
        end
        ST_MATCH: if (wrStrobe) begin
          if (wrBit != addrBit) stateNext = ST_WAIT;
          else if (lastBit)     stateNext = ST_SEL;
          else                  ctl.idxInc = 1'b1;
        end
        ST_SRCH_TRUE: if (rdStrobe) stateNext = ST_SRCH_COMP;
        ST_SRCH_COMP: if (rdStrobe) stateNext = ST_SRCH_PICK;
        ST_SRCH_PICK: if (wrStrobe) begin
          if (wrBit != addrBit) begin
            stateNext = ST_WAIT;
          end else if (lastBit) begin
            stateNext = ST_SEL;
          end else begin
            ctl.idxInc = 1'b1;
            stateNext  = ST_SRCH_TRUE;
          end
        end
        default: stateNext = state;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_READ, ST_SRCH_TRUE: txBit = addrBit;
      ST_SRCH_COMP:          txBit = ~addrBit;
      default:               txBit = 1'b1;
    endcase
  end

  assign selected = (state == ST_SEL);

endmodule

// File: rtl/ow_net_addr.sv
module ow_net_addr
  import ow_net_addr_pkg::*;
#(
  parameter logic [FAMILY_W-1:0] FAMILY_CODE = 8'h30,
  parameter logic [SERIAL_W-1:0] SERIAL_NUM  = 48'h0000_5A3C_9E71
) (
  input  logic clk,
  input  logic rstN,
  input  logic busReset,
  input  logic wrStrobe,
  input  logic wrBit,
  input  logic rdStrobe,
  output logic txBit,
  output logic selected
);

  dp_ctl_t          ctl;
  logic             addrBit;
  logic             lastBit;
  logic [CMD_W-1:0] cmdNext;
  logic             cmdFull;

  ow_net_addr_dp #(
    .FAMILY_CODE(FAMILY_CODE),
    .SERIAL_NUM (SERIAL_NUM)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .wrBit  (wrBit),
    .addrBit(addrBit),
    .lastBit(lastBit),
    .cmdNext(cmdNext),
    .cmdFull(cmdFull)
  );

  ow_net_addr_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busReset(busReset),
    .wrStrobe(wrStrobe),
    .wrBit   (wrBit),
    .rdStrobe(rdStrobe),
    .addrBit (addrBit),
    .lastBit (lastBit),
    .cmdNext (cmdNext),
    .cmdFull (cmdFull),
    .ctl     (ctl),
    .txBit   (txBit),
    .selected(selected)
  );

endmodule

// File: rtl/ow_net_addr_chk.sv
module ow_net_addr_chk (
  input logic clk,
  input logic rstN,
  input logic busReset,
  input logic wrStrobe,
  input logic rdStrobe,
  input logic txBit,
  input logic selected
);

  // R7: a bus reset always clears the selection
  p_reset_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> !selected);

  // R7: command collection after a bus reset keeps the line released
  p_reset_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> txBit);

  // R4: selection is held until a bus reset
  p_sel_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (selected && !busReset) |=> selected);

  // R9: no pull-down while selected
  p_release_sel_r9: assert property (@(posedge clk) disable iff (!rstN)
    selected |-> txBit);

  // R5: selection only ever follows a completed slot
  p_sel_after_slot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selected) |-> ($past(wrStrobe) || $past(rdStrobe)));

endmodule

bind ow_net_addr ow_net_addr_chk i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busReset(busReset),
  .wrStrobe(wrStrobe),
  .rdStrobe(rdStrobe),
  .txBit   (txBit),
  .selected(selected)
);

// File: tb/test_ow_net_addr.sv
`timescale 1ns/1ps
module test_ow_net_addr;

  localparam logic [7:0]  FAM   = 8'h30;
  localparam logic [47:0] SER   = 48'h0000_5A3C_9E71;
  localparam logic [7:0]  K_FAM = 8'h02;
  localparam logic [47:0] K_SER = 48'h0000_0001_B81C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReset = 1'b0;
  logic wrStrobe = 1'b0;
  logic wrBit = 1'b0;
  logic rdStrobe = 1'b0;
  logic txBit, selected, kTxBit, kSelected;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  ow_net_addr #(.FAMILY_CODE(FAM), .SERIAL_NUM(SER)) i_ow_net_addr (
    .clk(clk), .rstN(rstN), .busReset(busReset), .wrStrobe(wrStrobe),
    .wrBit(wrBit), .rdStrobe(rdStrobe), .txBit(txBit), .selected(selected));

  ow_net_addr #(.FAMILY_CODE(K_FAM), .SERIAL_NUM(K_SER)) i_ow_net_addrKnown (
    .clk(clk), .rstN(rstN), .busReset(busReset), .wrStrobe(wrStrobe),
    .wrBit(wrBit), .rdStrobe(rdStrobe), .txBit(kTxBit), .selected(kSelected));

  function automatic logic [7:0] benchCrc(input logic [55:0] body);
    int c;
    c = 0;
    for (int i = 0; i < 56; i++) begin
      if (((c ^ int'(body[i])) & 1) != 0) c = (c >> 1) ^ 'h8C;
      else                               c = c >> 1;
    end
    return 8'(c);
  endfunction

  logic [63:0] expAddr;
  initial expAddr = {benchCrc({SER, FAM}), SER, FAM};

  // behavioural model: 0 wait, 1 cmd, 2 read, 3 match, 4 true, 5 comp, 6 pick, 7 selected
  int mMode = 0;
  int mIdx = 0;
  int mCnt = 0;
  logic [7:0] mCmd = '0;

  always @(posedge clk) begin
    cyc++;
    if (!rstN) mMode = 0;
    else if (busReset) begin mMode = 1; mIdx = 0; mCnt = 0; mCmd = '0; end
    else begin
      case (mMode)
        1: if (wrStrobe) begin
          mCmd = {wrBit, mCmd[7:1]}; mCnt++;
          if (mCnt == 8) begin
            if (mCmd == 8'h33) mMode = 2;
            else if (mCmd == 8'h55) mMode = 3;
            else if (mCmd == 8'hCC) mMode = 7;
            else if (mCmd == 8'hF0) mMode = 4;
            else mMode = 0;
          end
        end
        2: if (rdStrobe) begin if (mIdx == 63) mMode = 7; else mIdx++; end
        3: if (wrStrobe) begin
          if (wrBit != expAddr[mIdx]) mMode = 0;
          else if (mIdx == 63) mMode = 7; else mIdx++;
        end
        4: if (rdStrobe) mMode = 5;
        5: if (rdStrobe) mMode = 6;
        6: if (wrStrobe) begin
          if (wrBit != expAddr[mIdx]) mMode = 0;
          else if (mIdx == 63) mMode = 7;
          else begin mIdx++; mMode = 4; end
        end
        default: ;
      endcase
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      logic eTx;
      eTx = 1'b1;
      if (mMode == 2 || mMode == 4) eTx = expAddr[mIdx];
      if (mMode == 5) eTx = ~expAddr[mIdx];
      checks++;
      if (txBit !== eTx || selected !== (mMode == 7)) begin
        errors++;
        $display("FAIL model compare R1/R5/R6/R9 at cycle %0d: actual tx=%b sel=%b expected tx=%b sel=%b",
                 cyc, txBit, selected, eTx, (mMode == 7));
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulseReset();
    @(negedge clk); busReset = 1'b1;
    @(negedge clk); busReset = 1'b0;
  endtask

  task automatic wrSlot(input logic b);
    @(negedge clk); wrBit = b; wrStrobe = 1'b1;
    @(negedge clk); wrStrobe = 1'b0;
  endtask

  task automatic rdSlot(output logic b, output logic kb);
    @(negedge clk); b = txBit; kb = kTxBit; rdStrobe = 1'b1;
    @(negedge clk); rdStrobe = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) wrSlot(v[i]);
  endtask

  logic [63:0] got, kGot;
  logic b, kb, b2, kb2;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 reset selected", 64'(selected), 64'd0);
    chk("R9 reset txBit", 64'(txBit), 64'd1);

    sendByte(8'hCC);
    chk("R9 ignored before first bus reset", 64'(selected), 64'd0);

    pulseReset(); sendByte(8'hCC);
    chk("R4 skip selects", 64'(selected), 64'd1);
    sendByte(8'h00); rdSlot(b, kb);
    chk("R4 selection sticky", 64'(selected), 64'd1);
    chk("R9 released while selected", 64'(b), 64'd1);
    pulseReset();
    chk("R7 reset clears selection", 64'(selected), 64'd0);

    // read address, with a stray write strobe in the middle
    sendByte(8'h33);
    for (int i = 0; i < 64; i++) begin
      rdSlot(b, kb); got[i] = b; kGot[i] = kb;
      if (i == 20) wrSlot(1'b0);
    end
    chk("R1 read address", got, expAddr);
    chk("R1 family code", 64'(got[7:0]), 64'h30);
    chk("R2 checksum", 64'(got[63:56]), 64'(benchCrc({SER, FAM})));
    chk("R2 known checksum A2h", 64'(kGot[63:56]), 64'hA2);
    chk("R10 stray write ignored in read", 64'(got[21]), 64'(expAddr[21]));
    chk("R1 selected after read", 64'(selected), 64'd1);

    // full match, with a stray read strobe
    pulseReset(); sendByte(8'h55);
    for (int i = 0; i < 64; i++) begin
      if (i == 30) begin rdSlot(b, kb); chk("R10 read in match released", 64'(b), 64'd1); end
      wrSlot(expAddr[i]);
    end
    chk("R5 full match selects", 64'(selected), 64'd1);

    // match failing at index 40
    pulseReset(); sendByte(8'h55);
    for (int i = 0; i < 64; i++) wrSlot(i == 40 ? ~expAddr[i] : expAddr[i]);
    chk("R5 mismatch not selected", 64'(selected), 64'd0);

    // full search
    pulseReset(); sendByte(8'hF0);
    for (int i = 0; i < 64; i++) begin
      rdSlot(b, kb); rdSlot(b2, kb2);
      got[i] = b;
      if (b2 !== ~expAddr[i]) chk("R6 complement bit", 64'(b2), 64'(~expAddr[i]));
      wrSlot(expAddr[i]);
    end
    chk("R6 search bits", got, expAddr);
    chk("R6 search selects", 64'(selected), 64'd1);

    // search withdrawal at index 10
    pulseReset(); sendByte(8'hF0);
    for (int i = 0; i < 11; i++) begin
      rdSlot(b, kb); rdSlot(b2, kb2);
      wrSlot(i == 10 ? ~expAddr[i] : expAddr[i]);
    end
    rdSlot(b, kb); rdSlot(b2, kb2);
    chk("R6 withdrawn true slot released", 64'(b), 64'd1);
    chk("R6 withdrawn comp slot released", 64'(b2), 64'd1);
    chk("R6 withdrawn not selected", 64'(selected), 64'd0);

    // unrecognised command
    pulseReset(); sendByte(8'hA5);
    rdSlot(b, kb);
    chk("R8 unknown command released", 64'(b), 64'd1);
    sendByte(8'hCC);
    chk("R8 later bytes not decoded", 64'(selected), 64'd0);

    // reset in the middle of a search and of a command byte
    pulseReset(); sendByte(8'hF0);
    rdSlot(b, kb); rdSlot(b2, kb2);
    pulseReset(); sendByte(8'hCC);
    chk("R7 reset aborts search", 64'(selected), 64'd1);
    pulseReset();
    for (int i = 0; i < 4; i++) wrSlot(1'b1);
    pulseReset(); sendByte(8'hCC);
    chk("R3 partial byte discarded", 64'(selected), 64'd1);

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule